// File: doc/BRIEF.md
# Address Match Breakpoint Unit

This unit watches the instruction-fetch port and the data-access port of a core and compares them against a small set of software-configured triggers. Each trigger has a control word and an address word. When a fetch or a data access falls on a trigger's address under the configured conditions, the unit raises a per-trigger hit. It also raises a combined breakpoint request in the same cycle, so the pipeline can take a breakpoint exception before the access takes effect.

A trigger fires only when it is armed. Being armed takes at least one enabled privilege mode and at least one enabled access kind (load, store or execute). Execute triggers need an exact match of the fetch address. Load and store triggers watch a byte window that starts at the trigger address. The window length comes from a size code, and the access's own byte range only has to overlap that window. Fetch and data comparisons run independently, and both may hit in the same cycle.

Control word layout (CTRL_W = 9 bits per trigger): bit 0 load, bit 1 store, bit 2 execute, bit 3 user, bit 4 supervisor, bit 5 machine, bits 8:6 size code. Trigger i occupies bits [i*CTRL_W +: CTRL_W] of the control bus and bits [i*XLEN +: XLEN] of the address bus.

Top module: `bp_match_unit`

## Requirements
- R1: A trigger never hits unless its control word has at least one of bits 3..5 set and at least one of bits 0..2 set.
- R2: With bit 2 set, a valid fetch hits exactly when the fetch address equals the trigger address; any other fetch address does not hit.
- R3: A data read (data_write_i=0) can hit only when bit 0 is set. A data write (data_write_i=1) can hit only when bit 1 is set. With both bits set, both kinds are watched.
- R4: Size codes 1, 2, 3 and 5 give watched windows of 1, 2, 4 and 8 bytes starting at the trigger address.
- R5: Size code 0 gives an 8-byte window. The unsupported codes 4, 6 and 7 also give an 8-byte window.
- R6: A data access of 2^data_size_i bytes at data_addr_i hits when its byte range overlaps the watched window, including partial overlap from below. Ranges that only touch the window edge do not hit.
- R7: A hit requires the enable bit of the current mode: priv_i=0 uses bit 3, priv_i=1 uses bit 4, priv_i=3 uses bit 5. priv_i=2 never hits.
- R8: hit_o and brk_o follow the inputs in the same cycle. brk_o is the OR of hit_o. A fetch hit and a data hit on different triggers appear together.
- R9: With fetch_valid_i and data_valid_i both low, no trigger hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used to sample the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| tctrl_i | input | NUM_TRIG*CTRL_W | Per-trigger control words |
| taddr_i | input | NUM_TRIG*XLEN | Per-trigger match addresses |
| priv_i | input | 2 | Current privilege mode (0 U, 1 S, 3 M) |
| fetch_valid_i | input | 1 | Instruction fetch present |
| fetch_addr_i | input | XLEN | Instruction fetch address |
| data_valid_i | input | 1 | Data access present |
| data_addr_i | input | XLEN | Data access start address |
| data_size_i | input | 2 | Log2 of the access size in bytes |
| data_write_i | input | 1 | 1 for a store, 0 for a load |
| hit_o | output | NUM_TRIG | Per-trigger hit |
| brk_o | output | 1 | Breakpoint request, suppresses the access |

## Verification
On every cycle, the embedded assertions check the following. A hit only occurs on an armed trigger, in a legal mode, with a valid access. A fetch hit carries an address equal to the trigger address. A data hit carries an access kind that the trigger enables. Every decoded window length is a single power of two. The exact window boundaries, the mapping of unsupported size codes to 8 bytes, the partial-overlap and edge-touching cases, and the OR into the breakpoint request can only be shown by the bench's scenarios. The bench compares each of these against its behavioural model.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int CTRL_W  = 9;
  localparam int B_LD    = 0;
  localparam int B_ST    = 1;
  localparam int B_EX    = 2;
  localparam int B_PU    = 3;
  localparam int B_PS    = 4;
  localparam int B_PM    = 5;
  localparam int B_SZ    = 6;
  localparam int SZ_W    = 3;
  localparam int WIN_W   = 4;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  function automatic logic [WIN_W-1:0] win_bytes(input logic [SZ_W-1:0] code);
    case (code)
      3'd1:    win_bytes = 4'd1;
      3'd2:    win_bytes = 4'd2;
      3'd3:    win_bytes = 4'd4;
      default: win_bytes = 4'd8;  // any-size and unsupported codes
    endcase
  endfunction
endpackage

// File: rtl/bp_cfg_decode.sv
module bp_cfg_decode
  import bp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [1:0]        priv_i,
  output logic              en_o,
  output logic              ld_o,
  output logic              st_o,
  output logic              ex_o,
  output logic [WIN_W-1:0]  win_o
);
  logic       armed;
  logic       mode_ok;
  logic [2:0] pen;

  assign pen   = {ctrl_i[B_PM], ctrl_i[B_PS], ctrl_i[B_PU]};
  assign armed = (|pen) && (|ctrl_i[B_EX:B_LD]);

  always_comb begin
    case (priv_e'(priv_i))
      PRIV_U:  mode_ok = pen[0];
      PRIV_S:  mode_ok = pen[1];
      PRIV_M:  mode_ok = pen[2];
      default: mode_ok = 1'b0;
    endcase
  end

  assign en_o  = armed && mode_ok;
  assign ld_o  = ctrl_i[B_LD];
  assign st_o  = ctrl_i[B_ST];
  assign ex_o  = ctrl_i[B_EX];
  assign win_o = win_bytes(ctrl_i[B_SZ +: SZ_W]);

  assert_win_pow2_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(win_o) == 1);
  assert_en_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> (priv_i != 2'd2));
endmodule

// File: rtl/bp_fetch_cmp.sv
module bp_fetch_cmp #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            ex_i,
  input  logic [XLEN-1:0] taddr_i,
  input  logic            valid_i,
  input  logic [XLEN-1:0] addr_i,
  output logic            hit_o
);
  assign hit_o = en_i && ex_i && valid_i && (addr_i == taddr_i);

  assert_fetch_exact_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (addr_i == taddr_i) && ex_i);
  assert_fetch_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !hit_o);
endmodule

// File: rtl/bp_data_cmp.sv
module bp_data_cmp
  import bp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ld_i,
  input  logic             st_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic [XLEN-1:0]  taddr_i,
  input  logic             valid_i,
  input  logic [XLEN-1:0]  addr_i,
  input  logic [1:0]       size_i,
  input  logic             write_i,
  output logic             hit_o
);
  localparam int AW = XLEN + 1;  // one guard bit so window ends never wrap

  logic [AW-1:0]    a_lo, a_hi, t_lo, t_hi;
  logic [WIN_W-1:0] nbytes;
  logic             kind_ok, overlap;

  assign nbytes  = WIN_W'(1) << size_i;
  assign a_lo    = AW'(addr_i);
  assign a_hi    = a_lo + AW'(nbytes);
  assign t_lo    = AW'(taddr_i);
  assign t_hi    = t_lo + AW'(win_i);
  assign overlap = (a_lo < t_hi) && (t_lo < a_hi);
  assign kind_ok = write_i ? st_i : ld_i;
  assign hit_o   = en_i && valid_i && kind_ok && overlap;

  assert_store_kind_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && write_i) |-> st_i);
  assert_load_kind_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !write_i) |-> ld_i);
  assert_data_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !hit_o);
endmodule

// File: rtl/bp_match_unit.sv
module bp_match_unit
  import bp_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_TRIG*CTRL_W-1:0] tctrl_i,
  input  logic [NUM_TRIG*XLEN-1:0]   taddr_i,
  input  logic [1:0]                 priv_i,
  input  logic                       fetch_valid_i,
  input  logic [XLEN-1:0]            fetch_addr_i,
  input  logic                       data_valid_i,
  input  logic [XLEN-1:0]            data_addr_i,
  input  logic [1:0]                 data_size_i,
  input  logic                       data_write_i,
  output logic [NUM_TRIG-1:0]        hit_o,
  output logic                       brk_o
);
  logic [NUM_TRIG-1:0] f_hit, d_hit;

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    logic             en, ld, st, ex;
    logic [WIN_W-1:0] win;
    logic [CTRL_W-1:0] ctrl;

    assign ctrl = tctrl_i[i*CTRL_W +: CTRL_W];

    bp_cfg_decode u_dec (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .ctrl_i(ctrl), .priv_i(priv_i),
      .en_o  (en), .ld_o(ld), .st_o(st), .ex_o(ex), .win_o(win)
    );

    bp_fetch_cmp #(.XLEN(XLEN)) u_fcmp (
      .clk_i  (clk_i), .rst_ni(rst_ni),
      .en_i   (en), .ex_i(ex),
      .taddr_i(taddr_i[i*XLEN +: XLEN]),
      .valid_i(fetch_valid_i), .addr_i(fetch_addr_i),
      .hit_o  (f_hit[i])
    );

    bp_data_cmp #(.XLEN(XLEN)) u_dcmp (
      .clk_i  (clk_i), .rst_ni(rst_ni),
      .en_i   (en), .ld_i(ld), .st_i(st), .win_i(win),
      .taddr_i(taddr_i[i*XLEN +: XLEN]),
      .valid_i(data_valid_i), .addr_i(data_addr_i),
      .size_i (data_size_i), .write_i(data_write_i),
      .hit_o  (d_hit[i])
    );

    assert_armed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o[i] |-> ((|ctrl[B_PM:B_PU]) && (|ctrl[B_EX:B_LD])));
  end

  assign hit_o = f_hit | d_hit;
  assign brk_o = |hit_o;

  assert_no_hit_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_valid_i && !data_valid_i) |-> !brk_o);
  assert_priv_rsv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == 2'd2) |-> (hit_o == '0));
endmodule

// File: tb/bp_match_unit_bench.sv
`timescale 1ns/1ps
module bp_match_unit_bench;
  localparam int XLEN = 32;
  localparam int NT   = 2;
  localparam int CW   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT*CW-1:0]   tctrl = '0;
  logic [NT*XLEN-1:0] taddr = '0;
  logic [1:0]         priv = 2'd3;
  logic               fv = 1'b0, dv = 1'b0, dw = 1'b0;
  logic [XLEN-1:0]    fa = '0, da = '0;
  logic [1:0]         dsz = '0;
  logic [NT-1:0]      hit;
  logic               brk;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bp_match_unit #(.XLEN(XLEN), .NUM_TRIG(NT)) u_bp_match_unit (
    .clk_i(clk), .rst_ni(rst_n), .tctrl_i(tctrl), .taddr_i(taddr),
    .priv_i(priv), .fetch_valid_i(fv), .fetch_addr_i(fa),
    .data_valid_i(dv), .data_addr_i(da), .data_size_i(dsz),
    .data_write_i(dw), .hit_o(hit), .brk_o(brk)
  );

  function automatic logic [CW-1:0] mk(bit ld, bit st, bit ex, bit u, bit s, bit m, int sz);
    logic [CW-1:0] c;
    c = '0;
    c[0] = ld; c[1] = st; c[2] = ex; c[3] = u; c[4] = s; c[5] = m;
    c[8:6] = 3'(sz);
    return c;
  endfunction

  function automatic bit model(int t);
    logic [CW-1:0] c;
    longint unsigned ta, win, nb, a;
    bit pok, armed, fh, dh;
    c  = tctrl[t*CW +: CW];
    ta = longint'(taddr[t*XLEN +: XLEN]);
    armed = (c[5:3] != 0) && (c[2:0] != 0);
    case (priv)
      2'd0: pok = c[3];
      2'd1: pok = c[4];
      2'd3: pok = c[5];
      default: pok = 0;
    endcase
    case (c[8:6])
      3'd1: win = 1; 3'd2: win = 2; 3'd3: win = 4;
      default: win = 8;
    endcase
    nb = 1 << dsz;
    a  = longint'(da);
    fh = fv && c[2] && (fa == taddr[t*XLEN +: XLEN]);
    dh = dv && (dw ? c[1] : c[0]) && (a < ta + win) && (ta < a + nb);
    return armed && pok && (fh || dh);
  endfunction

  task automatic check(string tag);
    logic [NT-1:0] eh;
    bit eb;
    @(negedge clk);
    for (int t = 0; t < NT; t++) eh[t] = model(t);
    eb = |eh;
    n_chk++;
    if (hit !== eh || brk !== eb) begin
      n_err++;
      $display("FAIL %s: hit=%b brk=%b expected hit=%b brk=%b", tag, hit, brk, eh, eb);
    end
    @(posedge clk); #0.5;
  endtask

  task automatic idle();
    fv = 0; dv = 0; dw = 0; dsz = 0; priv = 2'd3;
  endtask

  task automatic rd(logic [XLEN-1:0] a, int s, string tag);
    dv = 1; dw = 0; da = a; dsz = 2'(s); check(tag); dv = 0;
  endtask

  task automatic wr(logic [XLEN-1:0] a, int s, string tag);
    dv = 1; dw = 1; da = a; dsz = 2'(s); check(tag); dv = 0;
  endtask

  task automatic fe(logic [XLEN-1:0] a, string tag);
    fv = 1; fa = a; check(tag); fv = 0;
  endtask

  initial begin
    #40000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // reset state: nothing valid, no hit (R9)
    tctrl = {mk(1,1,1,1,1,1,0), mk(1,1,1,1,1,1,0)};
    taddr = {32'h0, 32'h0};
    check("R9 reset");
    rst_n = 1;
    @(posedge clk); #0.5;
    check("R9 idle");

    // R1: unarmed triggers
    taddr = {32'h0, 32'h100};
    tctrl = {mk(0,0,0,0,0,0,0), mk(0,0,1,0,0,0,0)};
    fe(32'h100, "R1 no priv bit");
    tctrl = {mk(0,0,0,0,0,0,0), mk(0,0,0,1,1,1,0)};
    fe(32'h100, "R1 no kind bit");
    rd(32'h100, 0, "R1 no kind bit read");

    // R2: exact fetch match
    tctrl = {mk(0,0,0,0,0,0,0), mk(0,0,1,0,0,1,0)};
    fe(32'h100, "R2 fetch equal");
    fe(32'h101, "R2 fetch off by one");
    fe(32'h0FF, "R2 fetch below");
    rd(32'h100, 0, "R3 exec only ignores read");

    // R3: access kinds
    tctrl = {mk(0,0,0,0,0,0,0), mk(1,0,0,0,0,1,1)};
    rd(32'h100, 0, "R3 load watched");
    wr(32'h100, 0, "R3 store ignored by load trigger");
    fe(32'h100, "R3 fetch ignored by load trigger");
    tctrl = {mk(0,0,0,0,0,0,0), mk(0,1,0,0,0,1,1)};
    wr(32'h100, 0, "R3 store watched");
    rd(32'h100, 0, "R3 load ignored by store trigger");
    tctrl = {mk(0,0,0,0,0,0,0), mk(1,1,0,0,0,1,1)};
    rd(32'h100, 0, "R3 both read");
    wr(32'h100, 0, "R3 both write");

    // R4: window lengths
    tctrl = {mk(0,0,0,0,0,0,0), mk(1,0,0,0,0,1,1)};
    rd(32'h100, 0, "R4 1B start");
    rd(32'h101, 0, "R4 1B past end");
    tctrl = {mk(0,0,0,0,0,0,0), mk(1,0,0,0,0,1,2)};
    rd(32'h101, 0, "R4 2B last");
    rd(32'h102, 0, "R4 2B past end");
    tctrl = {mk(0,0,0,0,0,0,0), mk(1,0,0,0,0,1,3)};
    rd(32'h103, 0, "R4 4B last");
    rd(32'h104, 0, "R4 4B past end");
    tctrl = {mk(0,0,0,0,0,0,0), mk(1,0,0,0,0,1,5)};
    rd(32'h107, 0, "R4 8B last");
    rd(32'h108, 0, "R4 8B past end");

    // R5: any-size and unsupported codes
    tctrl = {mk(0,0,0,0,0,0,0), mk(1,0,0,0,0,1,0)};
    rd(32'h107, 0, "R5 code0 last");
    rd(32'h108, 0, "R5 code0 past end");
    tctrl = {mk(0,0,0,0,0,0,0), mk(1,0,0,0,0,1,4)};
    rd(32'h107, 0, "R5 code4 last");
    tctrl = {mk(0,0,0,0,0,0,0), mk(1,0,0,0,0,1,6)};
    rd(32'h107, 0, "R5 code6 last");
    tctrl = {mk(0,0,0,0,0,0,0), mk(1,0,0,0,0,1,7)};
    rd(32'h108, 0, "R5 code7 past end");

    // R6: overlap with multi-byte accesses
    tctrl = {mk(0,0,0,0,0,0,0), mk(1,0,0,0,0,1,1)};
    rd(32'h0FD, 2, "R6 4B from below overlaps");
    rd(32'h0FC, 2, "R6 4B touching below");
    rd(32'h0F8, 3, "R6 8B touching below");
    rd(32'h0FA, 3, "R6 8B overlaps");
    rd(32'h0FF, 1, "R6 2B straddles");
    taddr = {32'h0, 32'hFFFF_FFFE};
    rd(32'hFFFF_FFFC, 3, "R6 top of space");
    taddr = {32'h0, 32'h100};

    // R7: privilege
    tctrl = {mk(0,0,0,0,0,0,0), mk(0,0,1,1,0,0,0)};
    priv = 2'd3; fe(32'h100, "R7 U-only in M");
    priv = 2'd0; fe(32'h100, "R7 U-only in U");
    priv = 2'd1; fe(32'h100, "R7 U-only in S");
    tctrl = {mk(0,0,0,0,0,0,0), mk(1,1,1,1,1,1,0)};
    priv = 2'd2; fe(32'h100, "R7 reserved mode");
    priv = 2'd1; fe(32'h100, "R7 all modes in S");
    idle();

    // R8: simultaneous fetch and data on separate triggers
    tctrl = {mk(1,0,0,0,0,1,3), mk(0,0,1,0,0,1,0)};
    taddr = {32'h2000, 32'h100};
    fv = 1; fa = 32'h100; dv = 1; dw = 0; da = 32'h2002; dsz = 0;
    check("R8 both hit");
    fa = 32'h104;
    check("R8 data only");
    idle();

    // R8: randomized stream compared every clock
    for (int k = 0; k < 400; k++) begin
      for (int t = 0; t < NT; t++) begin
        tctrl[t*CW +: CW]   = CW'($urandom);
        taddr[t*XLEN +: XLEN] = 32'h1000 + ($urandom % 24);
      end
      priv = 2'($urandom);
      fv = 1'($urandom); fa = 32'h1000 + ($urandom % 24);
      dv = 1'($urandom); dw = 1'($urandom);
      da = 32'h0FF8 + ($urandom % 40); dsz = 2'($urandom);
      check("R8 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule